// File: doc/BRIEF.md
# Bus-Addressed Scan Test Wrapper

This wrapper sits between a pipelined, write-only test bus and an embedded core that carries parallel scan chains. Each write's address phase picks one of four targets: the scan chain group, the primary-input register, a capture command, or a view of the captured primary outputs. The data phase that follows then does the work. A chain write shifts one bit into every chain, with chain i taking write-data bit i. The bits that leave the chains on that shift are kept and placed on the read-data path. Loading the next pattern therefore unloads the previous response in the same transaction, and no read transfer is ever needed.

A small clock-enable generator inside the wrapper produces the shift enable for the core. For every capture command it produces exactly one single-cycle capture pulse. The primary outputs are latched on that same pulse. After a capture, the wrapper inserts one wait state, and scan enable stays low for that cycle. When the test-mode pin is low, the wrapper goes quiet: read data and primary inputs come from the functional path unchanged, no enables fire, and the test registers keep their contents.

Top module: `scan_wrap_top`

## Requirements
- R1: After reset, scan_en, shift_clk_en and cap_pulse are low and bus_ready is high. In test mode, bus_rdata and core_pi read zero.
- R2: A write accepted with bus_addr[3:2]=0 gives a data phase in which scan_en and shift_clk_en are high for one cycle, and core_si[i] equals bus_wdata[i].
- R3: The core_so bits present during a chain data phase appear on bus_rdata[NCH-1:0] from the next cycle on, with the upper bits zero.
- R4: A write with bus_addr[3:2]=1 loads bus_wdata[PI_W-1:0] into the primary-input register. In test mode, core_pi shows the new value from the next cycle on, and no shift occurs.
- R5: A write with bus_addr[3:2]=2 raises cap_pulse for exactly one cycle in its data phase, whatever the write data. po_in is latched at the end of that cycle.
- R6: In the cycle after a capture pulse, bus_ready and scan_en are low. A transfer pending in that cycle completes in the following cycle.
- R7: A write with bus_addr[3:2]=3 places the latched primary outputs, zero-extended, on bus_rdata from the cycle after its data phase.
- R8: Address phases with bus_write low or bus_sel low change no test state and produce no enable.
- R9: With test_mode low, bus_rdata equals func_rdata, core_pi equals func_pi, bus_ready is high, no enable fires, and writes leave the test registers unchanged.
- R10: Back-to-back writes complete one per cycle when no capture intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | High selects test operation |
| bus_sel | input | 1 | Address-phase select |
| bus_write | input | 1 | Address-phase write flag |
| bus_addr | input | ADDR_W | Address-phase byte offset |
| bus_wdata | input | DW | Data-phase write data |
| bus_ready | output | 1 | Low inserts a wait state |
| bus_rdata | output | DW | Read-data path (scan-out, PO view or functional data) |
| func_rdata | input | DW | Functional read data passed through in normal mode |
| func_pi | input | PI_W | Functional primary inputs for normal mode |
| core_pi | output | PI_W | Primary inputs to the core |
| po_in | input | PO_W | Primary outputs from the core |
| core_si | output | NCH | Scan-in bit per chain |
| core_so | input | NCH | Scan-out bit per chain |
| scan_en | output | 1 | Scan shift enable |
| shift_clk_en | output | 1 | Shift clock enable for the chains |
| cap_pulse | output | 1 | Single capture clock enable |

## Verification
The bench keeps the default NCH=32 and DW=32, so every bit lane of the write and read data is mapped to a chain. It uses narrower PI_W=12 and PO_W=10, which brings the zero-extension of the primary-output view and the truncation of primary-input write data within reach. The modelled core has chains of eight flops, so a response captured after several shifts drains back through bus_rdata. The capture-to-shift wait state is exercised with back-to-back transfers.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  typedef enum logic [1:0] {
    TGT_CHAIN = 2'd0,
    TGT_PI    = 2'd1,
    TGT_CAP   = 2'd2,
    TGT_POVW  = 2'd3
  } tgt_e;
endpackage

// File: rtl/scan_addr_dec.sv
module scan_addr_dec
  import scan_wrap_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ready,
  output logic              dp_valid,
  output tgt_e              dp_tgt
);
  logic dp_valid_nxt;
  tgt_e dp_tgt_nxt;
  logic accept;

  assign accept = test_mode & bus_sel & bus_write;

  always_comb begin
    dp_valid_nxt = dp_valid;
    dp_tgt_nxt   = dp_tgt;
    if (ready) begin
      dp_valid_nxt = accept;
      if (accept) dp_tgt_nxt = tgt_e'(bus_addr[3:2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_tgt   <= TGT_CHAIN;
    end else begin
      dp_valid <= dp_valid_nxt;
      dp_tgt   <= dp_tgt_nxt;
    end
  end
endmodule

// File: rtl/scan_clk_gen.sv
module scan_clk_gen
  import scan_wrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic dp_valid,
  input  tgt_e dp_tgt,
  output logic ready,
  output logic act,
  output logic scan_en,
  output logic shift_clk_en,
  output logic cap_pulse
);
  logic gap, gap_nxt;

  assign ready        = ~(test_mode & gap);
  assign act          = test_mode & dp_valid & ~gap;
  assign scan_en      = act & (dp_tgt == TGT_CHAIN);
  assign shift_clk_en = scan_en;
  assign cap_pulse    = act & (dp_tgt == TGT_CAP);

  always_comb begin
    gap_nxt = cap_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 1'b0;
    else        gap <= gap_nxt;
  end
endmodule

// File: rtl/scan_out_path.sv
module scan_out_path
  import scan_wrap_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCH  = 32,
  parameter int PI_W = 16,
  parameter int PO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_mode,
  input  logic            act,
  input  tgt_e            dp_tgt,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   func_rdata,
  input  logic [PI_W-1:0] func_pi,
  input  logic [PO_W-1:0] po_in,
  input  logic [NCH-1:0]  core_so,
  output logic [DW-1:0]   bus_rdata,
  output logic [PI_W-1:0] core_pi,
  output logic [NCH-1:0]  core_si
);
  localparam int SO_PAD = DW - NCH;
  localparam int PO_PAD = DW - PO_W;

  logic [DW-1:0]   out_q, out_nxt;
  logic [PI_W-1:0] pi_q, pi_nxt;
  logic [PO_W-1:0] po_q, po_nxt;
  logic            out_en, pi_en, po_en;
  logic [DW-1:0]   so_ext, po_ext;

  generate
    if (SO_PAD > 0) begin : g_so_pad
      assign so_ext = {{SO_PAD{1'b0}}, core_so};
    end else begin : g_so_full
      assign so_ext = core_so;
    end
    if (PO_PAD > 0) begin : g_po_pad
      assign po_ext = {{PO_PAD{1'b0}}, po_q};
    end else begin : g_po_full
      assign po_ext = po_q;
    end
  endgenerate

  always_comb begin
    out_en  = act & ((dp_tgt == TGT_CHAIN) | (dp_tgt == TGT_POVW));
    pi_en   = act & (dp_tgt == TGT_PI);
    po_en   = act & (dp_tgt == TGT_CAP);
    out_nxt = (dp_tgt == TGT_CHAIN) ? so_ext : po_ext;
    pi_nxt  = bus_wdata[PI_W-1:0];
    po_nxt  = po_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      pi_q  <= '0;
      po_q  <= '0;
    end else begin
      if (out_en) out_q <= out_nxt;
      if (pi_en)  pi_q  <= pi_nxt;
      if (po_en)  po_q  <= po_nxt;
    end
  end

  assign core_si   = bus_wdata[NCH-1:0];
  assign bus_rdata = test_mode ? out_q : func_rdata;
  assign core_pi   = test_mode ? pi_q  : func_pi;
endmodule

// File: rtl/scan_wrap_top.sv
module scan_wrap_top
  import scan_wrap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NCH    = 32,
  parameter int PI_W   = 16,
  parameter int PO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_ready,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     func_rdata,
  input  logic [PI_W-1:0]   func_pi,
  output logic [PI_W-1:0]   core_pi,
  input  logic [PO_W-1:0]   po_in,
  output logic [NCH-1:0]    core_si,
  input  logic [NCH-1:0]    core_so,
  output logic              scan_en,
  output logic              shift_clk_en,
  output logic              cap_pulse
);
  logic dp_valid, act;
  tgt_e dp_tgt;

  scan_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .ready(bus_ready), .dp_valid(dp_valid), .dp_tgt(dp_tgt)
  );

  scan_clk_gen u_ckg (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .dp_valid(dp_valid), .dp_tgt(dp_tgt), .ready(bus_ready), .act(act),
    .scan_en(scan_en), .shift_clk_en(shift_clk_en), .cap_pulse(cap_pulse)
  );

  scan_out_path #(.DW(DW), .NCH(NCH), .PI_W(PI_W), .PO_W(PO_W)) u_out (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .act(act),
    .dp_tgt(dp_tgt), .bus_wdata(bus_wdata), .func_rdata(func_rdata),
    .func_pi(func_pi), .po_in(po_in), .core_so(core_so),
    .bus_rdata(bus_rdata), .core_pi(core_pi), .core_si(core_si)
  );
endmodule

// File: rtl/scan_wrap_chk.sv
module scan_wrap_chk (
  input logic clk,
  input logic rst_n,
  input logic test_mode,
  input logic scan_en,
  input logic shift_clk_en,
  input logic cap_pulse,
  input logic bus_ready
);
  p_cap_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> (!scan_en && !bus_ready));
  p_single_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
  p_normal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (!scan_en && !shift_clk_en && !cap_pulse && bus_ready));
  p_no_shift_in_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_clk_en && cap_pulse));
  p_stall_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && test_mode) |=> bus_ready);
endmodule

bind scan_wrap_top scan_wrap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
  .shift_clk_en(shift_clk_en), .cap_pulse(cap_pulse), .bus_ready(bus_ready)
);

// File: tb/scan_wrap_top_tb.sv
module scan_wrap_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, DW = 32, NCH = 32, PI_W = 12, PO_W = 10;
  localparam int CLEN = 8;

  logic clk = 1'b0, rst_n = 1'b0, test_mode = 1'b1;
  logic bus_sel = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, func_rdata = 32'hFEED_0001;
  logic [PI_W-1:0] func_pi = 12'h3C3;
  logic bus_ready, scan_en, shift_clk_en, cap_pulse;
  logic [DW-1:0] bus_rdata;
  logic [PI_W-1:0] core_pi;
  logic [PO_W-1:0] po_in;
  logic [NCH-1:0] core_si, core_so;

  int checks = 0, fails = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_wrap_top #(.ADDR_W(ADDR_W), .DW(DW), .NCH(NCH), .PI_W(PI_W), .PO_W(PO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_sel(bus_sel),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .func_rdata(func_rdata),
    .func_pi(func_pi), .core_pi(core_pi), .po_in(po_in), .core_si(core_si),
    .core_so(core_so), .scan_en(scan_en), .shift_clk_en(shift_clk_en),
    .cap_pulse(cap_pulse)
  );

  // behavioural core: chains shift on the wrapper's enable, invert on capture
  logic [CLEN-1:0] chain [NCH];
  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (shift_clk_en)   chain[i] <= {chain[i][CLEN-2:0], core_si[i]};
      else if (cap_pulse) chain[i] <= ~chain[i];
    end
  end
  always_comb begin
    for (int i = 0; i < NCH; i++) core_so[i] = chain[i][CLEN-1];
  end
  assign po_in = core_pi[PO_W-1:0] ^ 10'h2A5;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  // reference model: queue of pending data-phase targets
  int pend[$];
  logic m_gap = 1'b0;
  logic [DW-1:0] m_out = '0;
  logic [PI_W-1:0] m_pi = '0;
  logic [PO_W-1:0] m_po = '0;
  logic s_sel, s_wr, s_tm;
  logic [ADDR_W-1:0] s_addr;
  logic [DW-1:0] s_wd;
  logic [NCH-1:0] s_so;
  logic [PO_W-1:0] s_po;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit e_act = s_tm_now() && pend.size() > 0 && !m_gap;
      chk("R6 bus_ready", bus_ready, !(test_mode && m_gap));
      chk("R2 scan_en", scan_en, e_act && pend[0] == 0);
      chk("R2 shift_clk_en", shift_clk_en, e_act && pend[0] == 0);
      chk("R5 cap_pulse", cap_pulse, e_act && pend[0] == 2);
      chk("R3/R7/R9 bus_rdata", bus_rdata, test_mode ? m_out : func_rdata);
      chk("R4/R9 core_pi", core_pi, test_mode ? m_pi : func_pi);
      if (scan_en) chk("R2 core_si", core_si, bus_wdata[NCH-1:0]);
    end
    s_sel = bus_sel; s_wr = bus_write; s_tm = test_mode; s_addr = bus_addr;
    s_wd = bus_wdata; s_so = core_so; s_po = po_in;
  end

  function automatic bit s_tm_now();
    return test_mode;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit rdy = !(s_tm && m_gap);
      automatic bit nxt_gap = 1'b0;
      if (s_tm && pend.size() > 0 && !m_gap) begin
        automatic int op = pend.pop_front();
        case (op)
          0: m_out = {{(DW-NCH){1'b0}}, s_so};
          1: m_pi = s_wd[PI_W-1:0];
          2: begin m_po = s_po; nxt_gap = 1'b1; end
          default: m_out = {{(DW-PO_W){1'b0}}, m_po};
        endcase
      end
      if (rdy) begin
        if (s_tm) pend.delete();
        if (s_sel && s_wr && s_tm) pend.push_back(int'(s_addr[3:2]));
      end
      m_gap = nxt_gap;
    end
  end

  // one bus cycle, held until accepted
  task automatic cyc(input logic sel, input logic wr, input logic [ADDR_W-1:0] a,
                     input logic [DW-1:0] d);
    bus_sel = sel; bus_write = wr; bus_addr = a; bus_wdata = d;
    forever begin
      @(negedge clk);
      if (bus_ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, '0, 32'h0BAD_F00D);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) chain[i] = CLEN'(i * 37);
    #(CLK_PERIOD*2 + 1);
    phase = "R1";
    chk("R1 reset scan_en", scan_en, 0);
    chk("R1 reset cap_pulse", cap_pulse, 0);
    chk("R1 reset bus_ready", bus_ready, 1);
    chk("R1 reset rdata", bus_rdata, 0);
    chk("R1 reset core_pi", core_pi, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2);

    phase = "R4";
    cyc(1, 1, 8'h04, '0); cyc(0, 0, 0, 32'hFFFF_F5A7); idle(2);
    chk("R4 pi loaded", core_pi, 12'h5A7);

    phase = "R2 R3 R10";
    for (int k = 0; k < CLEN; k++) begin
      cyc(1, 1, 8'h00, (k == 0) ? 32'h0 : 32'hC0DE_0000 + 32'(k) * 32'h1111_0101);
    end
    cyc(0, 0, 0, 32'hC0DE_0000 + 32'(CLEN) * 32'h1111_0101);
    idle(2);

    phase = "R5 R6";
    cyc(1, 1, 8'h08, '0);
    cyc(1, 1, 8'h00, 32'hDEAD_BEEF);   // capture data phase; chain addr pending
    cyc(0, 0, 0, 32'h1234_5678);       // stalled one cycle, then shifts
    idle(2);

    phase = "R7";
    cyc(1, 1, 8'h0C, '0); cyc(0, 0, 0, 32'hFFFF_FFFF); idle(1);
    chk("R7 po view", bus_rdata, {22'h0, 10'h5A7 ^ 10'h2A5});

    phase = "R8";
    cyc(1, 0, 8'h04, '0); cyc(0, 0, 0, 32'h0000_0111);
    cyc(1, 0, 8'h08, '0); cyc(0, 1, 8'h00, 32'h0); idle(2);
    chk("R8 pi unchanged", core_pi, 12'h5A7);

    phase = "R9";
    test_mode = 1'b0; idle(1);
    cyc(1, 1, 8'h04, '0); cyc(1, 1, 8'h08, 32'h0000_0999);
    cyc(0, 0, 0, 32'h0); idle(1);
    chk("R9 rdata pass", bus_rdata, func_rdata);
    test_mode = 1'b1; idle(1);
    chk("R9 pi kept", core_pi, 12'h5A7);

    phase = "R3 drain";
    for (int k = 0; k < CLEN + 1; k++) cyc(1, 1, 8'h00, 32'(k) * 32'h0F0F_1234);
    cyc(0, 0, 0, 32'h0); idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule